// File: doc/BRIEF.md
# One-Bit FIR Decimation Filter

This block takes the single-bit output of an oversampling delta-sigma modulator and turns it into signed multi-bit samples at a lower rate. Every accepted bit is shifted into a tap register. The filter output is the sum of one fixed weight per tap. A tap holding a one contributes its weight. A tap holding a zero contributes nothing in unipolar form, or the negated weight in bipolar form. No multipliers are needed.

The sum is formed every cycle, but only one result out of every `DECIM` accepted bits is kept. That result is registered and announced with a one-cycle strobe; the results in between are dropped. The weights follow a symmetric triangular profile computed from parameters, which gives a simple low-pass response. No output is produced until the tap register has been completely filled with real input bits.

Top module: `onebit_decim_fir`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `outValid` is 0 and `outSample` is 0.
- R2: A bit enters the taps only on a cycle where `inValid` is 1. When `inValid` is 0, the value on `inBit` has no effect on any later output.
- R3: Tap k (k=0 holds the newest accepted bit) has weight `COEF_SCALE*(k+1)` for k < TAPS/2, and `COEF_SCALE*(TAPS-k)` otherwise.
- R4: With `BIPOLAR`=0, a result is the sum of the weights of all taps holding 1. Taps holding 0 add nothing.
- R5: With `BIPOLAR`=1, a tap holding 1 adds its weight and a tap holding 0 subtracts it. A stream of alternating 1s and 0s therefore gives a result of 0.
- R6: A result is taken after every `DECIM`-th accepted bit (default 128). `outValid` is high for exactly one cycle, on the second rising edge after the edge that accepted that bit. It is never high on two cycles in a row.
- R7: No result is issued until at least `TAPS` bits have been accepted since reset. Decimation points that come before this are skipped.
- R8: `outSample` holds its value on every cycle where `outValid` is 0.
- R9: `outSample` is `COEF_W+clog2(TAPS)` bits wide and cannot overflow. A full register of ones gives the exact total of all weights (+4352 at the defaults), and a full register of zeros in bipolar form gives -4352.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inBit` on this cycle |
| inBit | input | 1 | Modulator bit: 1 stands for +V, 0 for -V |
| outValid | output | 1 | One-cycle strobe marking a new decimated result |
| outSample | output | COEF_W+clog2(TAPS) | Signed filter result, held between strobes |

## Verification
The bench drives two instances from the same stimulus: the bipolar default, and a unipolar variant that decimates by 8. The small ratio lets the fill-suppression window fall across several decimation points, so a design that issued results before the taps were full would produce strobes at bits 8, 16 and 24. An impulse walked through the taps exposes a weight profile that is mirrored or off by one tap, and all-ones and alternating streams reveal a truncated accumulator or a wrong sign for zero taps. Stretches with gaps in `inValid` and a toggling `inBit` catch a design that shifts or counts phase on unqualified cycles: its results would drift from the reference or its strobes would come early.

// File: rtl/onebit_decim_pkg.sv
package onebit_decim_pkg;

  // strobes passed from the control half to the datapath half
  typedef struct packed {
    logic shiftEn;   // accept inBit into the tap register this cycle
    logic capture;   // register the current sum as a decimated result
  } decimCtl_t;

  // triangular weight profile, tap 0 = newest bit
  function automatic int tapWeight(input int k, input int taps, input int scale);
    return (k < taps / 2) ? scale * (k + 1) : scale * (taps - k);
  endfunction

endpackage

// File: rtl/decim_control.sv
module decim_control
  import onebit_decim_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int DECIM = 128
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output decimCtl_t ctl
);
  localparam int PH_W   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam int FILL_W = $clog2(TAPS + 1);

  logic [PH_W-1:0]   phase;
  logic [FILL_W-1:0] fillCnt;
  logic              pend;
  logic              lastPhase;
  logic              filled;

  assign lastPhase = (phase == PH_W'(DECIM - 1));
  // the bit accepted now completes the fill when fillCnt already holds TAPS-1
  assign filled    = (fillCnt >= FILL_W'(TAPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      fillCnt <= '0;
      pend    <= 1'b0;
    end else begin
      pend <= inValid && lastPhase && filled;
      if (inValid) begin
        phase <= lastPhase ? '0 : phase + 1'b1;
        if (fillCnt != FILL_W'(TAPS)) fillCnt <= fillCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.shiftEn = inValid;
    ctl.capture = pend;
  end
endmodule

// File: rtl/decim_datapath.sv
module decim_datapath
  import onebit_decim_pkg::*;
#(
  parameter int TAPS       = 32,
  parameter int COEF_W     = 12,
  parameter int COEF_SCALE = 16,
  parameter bit BIPOLAR    = 1'b1,
  parameter int ACC_W      = COEF_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inBit,
  input  decimCtl_t               ctl,
  output logic                    outValid,
  output logic signed [ACC_W-1:0] outSample
);
  logic [TAPS-1:0]         tapBits;
  logic signed [ACC_W-1:0] term [TAPS];
  logic signed [ACC_W-1:0] sum;

  always_ff @(posedge clk) begin
    if (rst) tapBits <= '0;
    else if (ctl.shiftEn) tapBits <= {tapBits[TAPS-2:0], inBit};
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam logic signed [COEF_W-1:0] COEF = COEF_W'(tapWeight(i, TAPS, COEF_SCALE));
    localparam logic signed [ACC_W-1:0]  WIDE = {{(ACC_W-COEF_W){COEF[COEF_W-1]}}, COEF};
    if (BIPOLAR) begin : g_bi
      assign term[i] = tapBits[i] ? WIDE : -WIDE;
    end else begin : g_uni
      assign term[i] = tapBits[i] ? WIDE : '0;
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + term[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) outSample <= sum;
    end
  end
endmodule

// File: rtl/onebit_decim_fir.sv
module onebit_decim_fir
  import onebit_decim_pkg::*;
#(
  parameter int TAPS       = 32,
  parameter int COEF_W     = 12,
  parameter int COEF_SCALE = 16,
  parameter int DECIM      = 128,
  parameter bit BIPOLAR    = 1'b1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   inValid,
  input  logic                                   inBit,
  output logic                                   outValid,
  output logic signed [COEF_W+$clog2(TAPS)-1:0]  outSample
);
  localparam int ACC_W = COEF_W + $clog2(TAPS);

  decimCtl_t ctl;

  decim_control #(.TAPS(TAPS), .DECIM(DECIM)) u_ctl (
    .clk(clk), .rst(rst), .inValid(inValid), .ctl(ctl)
  );

  decim_datapath #(
    .TAPS(TAPS), .COEF_W(COEF_W), .COEF_SCALE(COEF_SCALE),
    .BIPOLAR(BIPOLAR), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .inBit(inBit), .ctl(ctl),
    .outValid(outValid), .outSample(outSample)
  );
endmodule

// File: rtl/onebit_decim_fir_chk.sv
module onebit_decim_fir_chk
  import onebit_decim_pkg::*;
#(
  parameter int TAPS       = 32,
  parameter int COEF_W     = 12,
  parameter int COEF_SCALE = 16,
  parameter int ACC_W      = COEF_W + $clog2(TAPS)
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    inValid,
  input logic                    outValid,
  input logic signed [ACC_W-1:0] outSample
);
  function automatic int weightTotal();
    int s = 0;
    for (int k = 0; k < TAPS; k++) s += tapWeight(k, TAPS, COEF_SCALE);
    return s;
  endfunction

  localparam logic signed [ACC_W-1:0] BND = ACC_W'(weightTotal());
  localparam int SEEN_W = $clog2(TAPS + 1);

  logic [SEEN_W-1:0] seenBits;
  always_ff @(posedge clk) begin
    if (rst) seenBits <= '0;
    else if (inValid && seenBits != SEEN_W'(TAPS)) seenBits <= seenBits + 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!outValid && outSample == '0));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  a_r6_follows_input: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 2));

  a_r7_filled_first: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (seenBits == SEEN_W'(TAPS)));

  a_r8_hold_value: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outSample));

  a_r9_in_range: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSample <= BND && outSample >= -BND));
endmodule

bind onebit_decim_fir onebit_decim_fir_chk #(
  .TAPS(TAPS), .COEF_W(COEF_W), .COEF_SCALE(COEF_SCALE), .ACC_W(ACC_W)
) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid),
  .outValid(outValid), .outSample(outSample)
);

// File: tb/onebit_decim_fir_tb.sv
module onebit_decim_fir_tb;
  localparam int CLK_P = 10;
  localparam int NT    = 32;
  localparam int SC    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic inBit = 1'b0;
  logic bipV, uniV;
  logic signed [16:0] bipS, uniS;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  onebit_decim_fir u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit),
    .outValid(bipV), .outSample(bipS)
  );

  onebit_decim_fir #(.DECIM(8), .BIPOLAR(1'b0)) u_uni (
    .clk(clk), .rst(rst), .inValid(inValid), .inBit(inBit),
    .outValid(uniV), .outSample(uniS)
  );

  // reference state
  bit hist[$];
  int nAcc;
  bit drvV, drvB;
  bit expBV, expUV;
  int expBS, expUS, heldB, heldU;
  int bipLast, uniLast, uniCount;

  function automatic int wt(input int k);
    return (k < NT/2) ? SC * (k + 1) : SC * (NT - k);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    hist.delete();
    for (int k = 0; k < NT; k++) hist.push_back(1'b0);
    nAcc = 0; drvV = 0; drvB = 0;
    expBV = 0; expUV = 0; expBS = 0; expUS = 0; heldB = 0; heldU = 0;
    uniCount = 0;
  endtask

  task automatic step(input bit v, input bit b);
    int sb, su;
    @(negedge clk);
    chk(bipV == expBV, "R6 bipolar strobe", int'(bipV), int'(expBV));
    if (expBV) begin
      chk(int'(bipS) == expBS, "R5 bipolar result", int'(bipS), expBS);
      bipLast = int'(bipS); heldB = expBS;
    end else chk(int'(bipS) == heldB, "R8 bipolar hold", int'(bipS), heldB);
    chk(uniV == expUV, "R7 unipolar strobe", int'(uniV), int'(expUV));
    if (expUV) begin
      chk(int'(uniS) == expUS, "R3 R4 unipolar result", int'(uniS), expUS);
      uniLast = int'(uniS); heldU = expUS; uniCount++;
    end else chk(int'(uniS) == heldU, "R8 unipolar hold", int'(uniS), heldU);
    // advance the reference by the edge that just passed (R2: only qualified bits)
    expBV = 0; expUV = 0;
    if (drvV) begin
      hist.push_front(drvB); void'(hist.pop_back());
      nAcc++;
      sb = 0; su = 0;
      for (int k = 0; k < NT; k++) begin
        sb += hist[k] ? wt(k) : -wt(k);
        su += hist[k] ? wt(k) : 0;
      end
      expBS = sb; expUS = su;
      expBV = (nAcc % 128 == 0) && (nAcc >= NT);
      expUV = (nAcc % 8 == 0) && (nAcc >= NT);
    end
    inValid = v; inBit = b; drvV = v; drvB = b;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bipV && bipS == 0, "R1 reset bipolar", int'(bipS), 0);
    chk(!uniV && uniS == 0, "R1 reset unipolar", int'(uniS), 0);
    rst = 1'b0;
    modelReset();
  endtask

  initial begin
    modelReset();
    bipLast = 0; uniLast = 0;
    doReset();
    step(0, 0);
    chk(!bipV && !uniV && bipS == 0, "R1 after reset", int'(bipS), 0);

    // alternating stream; R7 fill suppression on the DECIM=8 instance
    for (int i = 0; i < 31; i++) step(1, i[0]);
    chk(uniCount == 0, "R7 no early result", uniCount, 0);
    for (int i = 31; i < 40; i++) step(1, i[0]);
    chk(uniCount == 1, "R7 first result at fill", uniCount, 1);
    for (int i = 40; i < 256; i++) step(1, i[0]);
    step(0, 1); step(0, 0);
    chk(bipLast == 0, "R5 alternating gives zero", bipLast, 0);

    // all ones: full weight total
    for (int i = 0; i < 128; i++) step(1, 1);
    step(0, 0); step(0, 1);
    chk(bipLast == 4352, "R9 bipolar full scale", bipLast, 4352);
    chk(uniLast == 4352, "R4 unipolar all ones", uniLast, 4352);

    // all zeros: negative full scale in bipolar form
    for (int i = 0; i < 128; i++) step(1, 0);
    step(0, 1); step(0, 1);
    chk(bipLast == -4352, "R9 bipolar negative scale", bipLast, -4352);

    // gaps with toggling inBit on idle cycles (R2), random density
    for (int i = 0; i < 1500; i++) begin
      bit vv = (($urandom % 3) != 0);
      step(vv, 1'($urandom));
    end
    step(0, 0); step(0, 0);

    // impulse walk through the taps (R3)
    doReset();
    for (int i = 0; i < 32; i++) step(1, 0);
    step(1, 1);
    for (int i = 0; i < 7; i++) step(1, 0);
    step(0, 1); step(0, 1);
    chk(uniLast == 128, "R3 weight of tap 7", uniLast, 128);
    for (int i = 0; i < 8; i++) step(1, 0);
    step(0, 1); step(0, 0);
    chk(uniLast == 256, "R3 weight of tap 15", uniLast, 256);
    for (int i = 0; i < 8; i++) step(1, 0);
    step(0, 0); step(0, 1);
    chk(uniLast == 144, "R3 weight of tap 23", uniLast, 144);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule